// File: doc/BRIEF.md
# 100BASE-TX Transmit Symbol Encoder

This block takes 4-bit transmit nibbles from a media-independent MAC interface and turns them into a serial symbol stream at the 125 Mb/s symbol rate. One clock drives everything. An internal divide-by-five slot counter produces a nibble strobe that tells the MAC when its nibble is consumed. Each accepted nibble becomes a 5-bit code group. Start and end delimiters are inserted at frame edges. The stream is sent MSB first through an additive scrambler and then through an NRZ-to-NRZI converter.

The scrambler state is seeded from a 5-bit station address when the block is in reset, so that stations on a shared board start from different sequences. Each of the three stages can be bypassed on its own: the code-group mapper, the scrambler and the NRZI converter. This lets a test set inject raw 5-bit symbols, watch the unscrambled stream, or take plain NRZ at the line pin. A parallel copy of the code group currently being serialized is provided for test.

Top module: `tx_symbol_encoder`

## Requirements
- R1: `nib_strobe` is high for exactly one cycle in every five, in the last bit slot of a code group. The MAC inputs are sampled at the rising edge that ends that cycle.
- R2: With the mapper active and no frame in progress, every code group is IDLE (11111) while `tx_en` is low.
- R3: When `tx_en` is first seen high, the two nibbles sampled at that strobe and the next one are replaced by J (11000) and then K (10001). K always follows J, whatever `tx_en` is.
- R4: After K, each nibble sampled with `tx_en` high maps as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101. Code-group bit 4 goes out first.
- R5: A nibble sampled with `tx_en` and `tx_err` both high after K is sent as HALT (00100).
- R6: The first strobe after K or data that samples `tx_en` low sends T (01101). The next strobe sends R (00111) whatever `tx_en` is. After that the block is idle again.
- R7: The scrambler is an 11-bit register s. Each cycle the key bit is s[10]^s[8], s shifts left taking the key into bit 0, and the key is XORed onto the serial bit. During reset s loads bit 0 = 1, bits 5:1 = `station_addr`, bits 10:6 = the inverted address. s is never all zero.
- R8: With NRZI active, `line_bit` toggles for a 1 and holds for a 0. `line_bit` lags the scrambled serial bit by one cycle.
- R9: With `byp_enc` high, each strobe sends {`tx_err`, `tx_nibble`} unchanged. No delimiters are inserted and `tx_en` has no effect.
- R10: With `byp_scr` high, the serial bit reaches the NRZI stage unscrambled. The scrambler keeps stepping.
- R11: With `byp_nrzi` high, `line_bit` is the scrambler output delayed by one cycle. The NRZI state keeps following the stream.
- R12: Reset is synchronous and active low. After a reset edge, `line_bit` is 0, `sym_tap` is 11111 and `nib_strobe` is low.
- R13: `sym_tap` holds the code group being serialized. It changes one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-rate clock |
| rst_n | input | 1 | Synchronous active-low reset; also loads the scrambler seed |
| station_addr | input | 5 | Strapped station address used as the scrambler seed |
| tx_nibble | input | 4 | Transmit data nibble |
| tx_en | input | 1 | Frame in progress |
| tx_err | input | 1 | Transmit error; fifth raw bit when the mapper is bypassed |
| byp_enc | input | 1 | Bypass code-group mapping |
| byp_scr | input | 1 | Bypass scrambling |
| byp_nrzi | input | 1 | Bypass NRZI conversion |
| nib_strobe | output | 1 | Nibble accept strobe |
| sym_tap | output | 5 | Code group currently being serialized |
| line_bit | output | 1 | Serial line bit |

## Verification
The assertions check these every cycle: the strobe spacing, that the scrambler state is never zero, that the NRZI level holds or flips with the serial bit, and that NRZ bypass passes the serial bit through. They also check the forced successions J→K and T→R and HALT on an errored nibble. Only the bench scenarios can show the complete frame: preamble nibbles dropped, all sixteen data mappings, delimiters around frames that start back to back, `tx_en` ignored during K and R, and the exact serial stream for several seeds and bypass mixes. The bench shows these by comparing against a behavioural model.

// File: rtl/txenc_pkg.sv
package txenc_pkg;
    localparam int CG_W  = 5;
    localparam int NIB_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_J,
        PH_K,
        PH_DATA,
        PH_T
    } phase_e;

    localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
    localparam logic [CG_W-1:0] CG_J    = 5'b11000;
    localparam logic [CG_W-1:0] CG_K    = 5'b10001;
    localparam logic [CG_W-1:0] CG_T    = 5'b01101;
    localparam logic [CG_W-1:0] CG_R    = 5'b00111;
    localparam logic [CG_W-1:0] CG_HALT = 5'b00100;

    function automatic logic [CG_W-1:0] map_nibble(input logic [NIB_W-1:0] n);
        logic [CG_W-1:0] c;
        unique case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/tx_cg_framer.sv
module tx_cg_framer
    import txenc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] tx_nibble,
    input  logic             tx_en,
    input  logic             tx_err,
    input  logic             byp_enc,
    output logic             nib_strobe,
    output logic             nrz_bit,
    output logic [CG_W-1:0]  code_tap
);
    localparam int SLOT_W = $clog2(CG_W);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CG_W - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        phase_e            phase;
        logic [CG_W-1:0]   shreg;
        logic [CG_W-1:0]   code;
    } framer_t;

    framer_t         st_d, st_q;
    logic            load;
    logic [CG_W-1:0] next_cg;
    phase_e          next_ph;

    always_comb begin
        st_d    = st_q;
        load    = (st_q.slot == LAST_SLOT);
        next_cg = CG_IDLE;
        next_ph = st_q.phase;
        if (byp_enc) begin
            next_cg = {tx_err, tx_nibble};
            next_ph = PH_IDLE;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    if (tx_en) begin
                        next_cg = CG_J;
                        next_ph = PH_J;
                    end
                end
                PH_J: begin
                    next_cg = CG_K;
                    next_ph = PH_K;
                end
                PH_K, PH_DATA: begin
                    if (tx_en) begin
                        next_cg = tx_err ? CG_HALT : map_nibble(tx_nibble);
                        next_ph = PH_DATA;
                    end else begin
                        next_cg = CG_T;
                        next_ph = PH_T;
                    end
                end
                PH_T: begin
                    next_cg = CG_R;
                    next_ph = PH_IDLE;
                end
                default: begin
                    next_cg = CG_IDLE;
                    next_ph = PH_IDLE;
                end
            endcase
        end
        if (load) begin
            st_d.slot  = '0;
            st_d.phase = next_ph;
            st_d.shreg = next_cg;
            st_d.code  = next_cg;
        end else begin
            st_d.slot  = st_q.slot + 1'b1;
            st_d.shreg = {st_q.shreg[CG_W-2:0], 1'b0};
        end
        if (!rst_n) begin
            st_d.slot  = '0;
            st_d.phase = PH_IDLE;
            st_d.shreg = CG_IDLE;
            st_d.code  = CG_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign nib_strobe = load;
    assign nrz_bit    = st_q.shreg[CG_W-1];
    assign code_tap   = st_q.code;

    // R1
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nib_strobe |=> !nib_strobe);

    // R3
    jk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !byp_enc && st_q.phase == PH_J) |=> (code_tap == CG_K));

    // R6
    tr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !byp_enc && st_q.phase == PH_T) |=> (code_tap == CG_R));

    // R5
    halt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !byp_enc && tx_en && tx_err &&
         (st_q.phase == PH_K || st_q.phase == PH_DATA)) |=> (code_tap == CG_HALT));
endmodule

// File: rtl/tx_lfsr_scrambler.sv
module tx_lfsr_scrambler #(
    parameter int LFSR_W = 11,
    parameter int TAP_HI = 10,
    parameter int TAP_LO = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              byp_scr,
    input  logic              nrz_in,
    output logic              scr_out
);
    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } scr_t;

    scr_t              st_d, st_q;
    logic              key;
    logic [LFSR_W-1:0] seed;

    always_comb begin
        seed    = '0;
        seed[0] = 1'b1;
        for (int i = 1; i < LFSR_W; i++) begin
            seed[i] = station_addr[(i-1) % ADDR_W] ^ (((i-1) / ADDR_W) % 2 == 1);
        end
    end

    always_comb begin
        st_d      = st_q;
        key       = st_q.lfsr[TAP_HI] ^ st_q.lfsr[TAP_LO];
        st_d.lfsr = {st_q.lfsr[LFSR_W-2:0], key};
        if (st_d.lfsr == '0) st_d.lfsr = seed;
        if (!rst_n)          st_d.lfsr = seed;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign scr_out = byp_scr ? nrz_in : (nrz_in ^ key);

    // R7
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lfsr != '0);
endmodule

// File: rtl/tx_nrzi_line.sv
module tx_nrzi_line (
    input  logic clk,
    input  logic rst_n,
    input  logic byp_nrzi,
    input  logic bit_in,
    output logic line_bit
);
    typedef struct packed {
        logic level;
        logic line;
    } nrzi_t;

    nrzi_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = st_q.level ^ bit_in;
        st_d.line  = byp_nrzi ? bit_in : st_d.level;
        if (!rst_n) begin
            st_d.level = 1'b0;
            st_d.line  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign line_bit = st_q.line;

    // R8
    nrzi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_nrzi && !bit_in) |=> (line_bit == $past(st_q.level)));

    // R8
    nrzi_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_nrzi && bit_in) |=> (line_bit != $past(st_q.level)));

    // R11
    nrz_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp_nrzi |=> (line_bit == $past(bit_in)));
endmodule

// File: rtl/tx_symbol_encoder.sv
module tx_symbol_encoder
    import txenc_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LFSR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic [NIB_W-1:0]  tx_nibble,
    input  logic              tx_en,
    input  logic              tx_err,
    input  logic              byp_enc,
    input  logic              byp_scr,
    input  logic              byp_nrzi,
    output logic              nib_strobe,
    output logic [CG_W-1:0]   sym_tap,
    output logic              line_bit
);
    logic nrz_bit;
    logic scr_bit;

    tx_cg_framer u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_nibble  (tx_nibble),
        .tx_en      (tx_en),
        .tx_err     (tx_err),
        .byp_enc    (byp_enc),
        .nib_strobe (nib_strobe),
        .nrz_bit    (nrz_bit),
        .code_tap   (sym_tap)
    );

    tx_lfsr_scrambler #(
        .LFSR_W (LFSR_W),
        .TAP_HI (LFSR_W - 1),
        .TAP_LO (LFSR_W - 3),
        .ADDR_W (ADDR_W)
    ) u_scr (
        .clk          (clk),
        .rst_n        (rst_n),
        .station_addr (station_addr),
        .byp_scr      (byp_scr),
        .nrz_in       (nrz_bit),
        .scr_out      (scr_bit)
    );

    tx_nrzi_line u_nrzi (
        .clk      (clk),
        .rst_n    (rst_n),
        .byp_nrzi (byp_nrzi),
        .bit_in   (scr_bit),
        .line_bit (line_bit)
    );
endmodule

// File: tb/tb_tx_symbol_encoder.sv
`timescale 1ns/1ps
module tb_tx_symbol_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] station_addr = 5'b10110;
    logic [3:0] tx_nibble = 4'h0;
    logic       tx_en = 1'b0;
    logic       tx_err = 1'b0;
    logic       byp_enc = 1'b0;
    logic       byp_scr = 1'b0;
    logic       byp_nrzi = 1'b0;
    logic       nib_strobe;
    logic [4:0] sym_tap;
    logic       line_bit;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    tx_symbol_encoder dut (
        .clk(clk), .rst_n(rst_n), .station_addr(station_addr),
        .tx_nibble(tx_nibble), .tx_en(tx_en), .tx_err(tx_err),
        .byp_enc(byp_enc), .byp_scr(byp_scr), .byp_nrzi(byp_nrzi),
        .nib_strobe(nib_strobe), .sym_tap(sym_tap), .line_bit(line_bit)
    );

    // R4 code table
    logic [4:0] tbl [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                             5'b01010, 5'b01011, 5'b01110, 5'b01111,
                             5'b10010, 5'b10011, 5'b10110, 5'b10111,
                             5'b11010, 5'b11011, 5'b11100, 5'b11101};

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit         m_live = 0;
    int         m_pos;
    int         m_ph;
    logic [4:0] m_code;
    logic [10:0] m_lf;
    logic       m_nrzi, m_line;

    always @(posedge clk) begin
        logic b, key, s;
        if (!rst_n) begin
            m_live = 1;
            m_pos  = 0;
            m_ph   = 0;
            m_code = 5'b11111;
            m_lf   = {~station_addr, station_addr, 1'b1};
            m_nrzi = 0;
            m_line = 0;
        end else begin
            b    = m_code[4 - m_pos];
            key  = m_lf[10] ^ m_lf[8];
            m_lf = {m_lf[9:0], key};
            s    = byp_scr ? b : (b ^ key);
            m_nrzi = m_nrzi ^ s;
            m_line = byp_nrzi ? s : m_nrzi;
            if (m_pos == 4) begin
                m_pos = 0;
                if (byp_enc) begin
                    m_code = {tx_err, tx_nibble};
                    m_ph   = 0;
                end else if (m_ph == 0) begin
                    m_code = tx_en ? 5'b11000 : 5'b11111;
                    m_ph   = tx_en ? 1 : 0;
                end else if (m_ph == 1) begin
                    m_code = 5'b10001;
                    m_ph   = 2;
                end else if (m_ph == 2) begin
                    if (tx_en) m_code = tx_err ? 5'b00100 : tbl[tx_nibble];
                    else       m_code = 5'b01101;
                    m_ph = tx_en ? 2 : 3;
                end else begin
                    m_code = 5'b00111;
                    m_ph   = 0;
                end
            end else begin
                m_pos++;
            end
        end
    end

    always @(negedge clk) begin
        if (m_live) begin
            check(nib_strobe == (m_pos == 4), "R1 strobe", 16'(nib_strobe), 16'(m_pos == 4));
            check(sym_tap == m_code, "R13 sym_tap", 16'(sym_tap), 16'(m_code));
            check(line_bit == m_line, "R7/R8 line_bit", 16'(line_bit), 16'(m_line));
        end
    end

    task automatic sym(input logic en, input logic er, input logic [3:0] nb,
                       input logic [4:0] exp, input string tag);
        @(negedge clk);
        while (!nib_strobe) @(negedge clk);
        tx_en = en; tx_err = er; tx_nibble = nb;
        @(negedge clk);
        check(sym_tap == exp, tag, 16'(sym_tap), 16'(exp));
    endtask

    task automatic do_reset(input logic [4:0] addr);
        @(negedge clk);
        rst_n = 0; station_addr = addr;
        tx_en = 0; tx_err = 0;
        repeat (3) @(negedge clk);
        check(line_bit == 1'b0, "R12 line", 16'(line_bit), 16'h0);
        check(sym_tap == 5'b11111, "R12 tap", 16'(sym_tap), 16'h1f);
        check(nib_strobe == 1'b0, "R12 strobe", 16'(nib_strobe), 16'h0);
        rst_n = 1;
    endtask

    initial begin
        logic prev;
        do_reset(5'b10110);
        sym(0, 0, 4'h3, 5'b11111, "R2 idle");
        sym(0, 1, 4'h9, 5'b11111, "R2 idle");
        sym(1, 0, 4'h5, 5'b11000, "R3 J");
        sym(0, 0, 4'h5, 5'b10001, "R3 K tx_en ignored");
        sym(0, 0, 4'h0, 5'b01101, "R6 T");
        sym(1, 0, 4'h0, 5'b00111, "R6 R tx_en ignored");
        sym(1, 0, 4'h5, 5'b11000, "R3 J");
        sym(1, 0, 4'h5, 5'b10001, "R3 K");
        for (int n = 0; n < 16; n++) sym(1, 0, 4'(n), tbl[n], "R4 data");
        sym(1, 1, 4'h3, 5'b00100, "R5 halt");
        sym(1, 0, 4'hA, 5'b10110, "R4 data after halt");
        sym(0, 0, 4'h0, 5'b01101, "R6 T");
        sym(0, 0, 4'h0, 5'b00111, "R6 R");
        sym(0, 0, 4'h0, 5'b11111, "R6 back to idle");

        // R10 + R8: unscrambled idle ones toggle the line every cycle
        byp_scr = 1;
        @(negedge clk); @(negedge clk);
        prev = line_bit;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(line_bit != prev, "R10 R8 toggle", 16'(line_bit), 16'(!prev));
            prev = line_bit;
        end

        // R11: plain NRZ idle stays at 1
        byp_nrzi = 1;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(line_bit == 1'b1, "R11 nrz", 16'(line_bit), 16'h1);
        end

        // R9: raw symbols
        byp_enc = 1;
        sym(1, 0, 4'hB, 5'b01011, "R9 raw");
        sym(0, 1, 4'h2, 5'b10010, "R9 raw err bit");
        sym(1, 0, 4'h0, 5'b00000, "R9 raw zeros");
        sym(0, 1, 4'h7, 5'b10111, "R9 raw tx_en ignored");
        byp_enc = 0; byp_nrzi = 0;
        sym(1, 0, 4'h5, 5'b11000, "R3 J after bypass");
        sym(1, 0, 4'h5, 5'b10001, "R3 K");
        sym(1, 0, 4'hC, 5'b11010, "R4 data");
        byp_scr = 0;
        sym(0, 0, 4'h0, 5'b01101, "R6 T");
        sym(0, 0, 4'h0, 5'b00111, "R6 R");

        // R7: other seeds, scrambled frame
        do_reset(5'b00000);
        sym(1, 0, 4'h5, 5'b11000, "R7 seed0 J");
        sym(1, 0, 4'h5, 5'b10001, "R7 seed0 K");
        sym(1, 0, 4'h1, 5'b01001, "R7 seed0 data");
        sym(0, 0, 4'h0, 5'b01101, "R7 seed0 T");
        do_reset(5'b11111);
        byp_nrzi = 1;
        sym(1, 0, 4'h7, 5'b11000, "R7 seed31 J");
        sym(1, 0, 4'h7, 5'b10001, "R7 seed31 K");
        sym(1, 0, 4'hE, 5'b11100, "R7 seed31 data");
        sym(0, 0, 4'h0, 5'b01101, "R7 seed31 T");
        repeat (20) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule